// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between an 8-bit CPU bus, the graphics pattern bus and the cartridge's ROM and RAM arrays. The CPU programs it by writing into its upper 32 KB window. There, a select register names one of eight bank registers, and a data register loads that bank register. The same writes set two layout mode bits and the nametable mirroring type. Everything the block drives from this state is combinational. A CPU program address becomes a physical program-ROM address in 8 KB pages. A pattern-table address becomes a physical pattern-ROM address in 1 KB pages. The 8 KB work-RAM window, the CPU read-data mux and the pattern-RAM write enable are decoded in the same way.

The program ROM size comes from a static configuration input, `cfg_prg_bank_cnt`, which gives the number of 8 KB pages. The two fixed program windows use the last page and the second-last page of that count.

Top module: `cart_mapper`

## Requirements
- R1: After reset all eight bank registers, both mode bits and the mirroring bit are zero. So CPU 0x8000–0x9FFF maps to page 0, and `mirror_mode` is 0 (vertical).
- R2: An even-address write in 0x8000–0x9FFF is a select write. Data bits [2:0] name the target bank register, bit 6 sets the program mode, bit 7 sets the pattern mode, and bit 5 changes nothing.
- R3: An odd-address write in 0x8000–0x9FFF stores the data in the targeted bank register. Registers 0 and 1 clear bit 0, registers 6 and 7 keep only bits [5:0], and registers 2–5 keep all 8 bits.
- R4: `prg_rom_addr` = page × 8192 + `cpu_addr[12:0]`. In program mode 0 the four 8 KB windows from 0x8000 upward take register 6, register 7, the second-last page and the last page. In mode 1 the first and third windows exchange, so the order is second-last, register 7, register 6, last.
- R5: With pattern ROM present, `chr_addr` = page × 1024 + offset. In pattern mode 0, 0x0000 and 0x0800 are 2 KB windows from registers 0 and 1, where the page is the register value plus `ppu_addr[10]`. The 1 KB windows 0x1000, 0x1400, 0x1800 and 0x1C00 use registers 2–5. Mode 1 exchanges the 0x0000 and 0x1000 halves.
- R6: An even-address write in 0xA000–0xBFFF stores data bit 0 as the mirroring bit. `mirror_mode` is 0 for vertical and 1 for horizontal. When `cfg_four_screen` is high it is 2 (four-screen), whatever the bit holds.
- R7: For CPU addresses 0x6000–0x7FFF, `wram_sel` is 1 and `wram_we` follows `cpu_we`. `wram_addr` is always `cpu_addr[12:0]`. Outside that range both `wram_sel` and `wram_we` are 0.
- R8: `chr_ram_we` is 1 only when `ppu_we` is high, `ppu_addr[13]` is 0 and `cfg_chr_rom_present` is 0. Without pattern ROM, `chr_addr` is `ppu_addr[12:0]` with no banking.
- R9: `cpu_rdata` is `rom_rdata` for 0x8000–0xFFFF, `wram_rdata` for 0x6000–0x7FFF, and 0x00 for every other address.
- R10: Writes to odd 0xA000–0xBFFF, to 0xC000–0xFFFF or below 0x8000 leave the bank registers, the mode bits and the mirroring bit unchanged.
- R11: Inside the register window, decoding uses only the 8 KB region and address bit 0. For example, 0x9FFE acts as select, 0x9FFF acts as data, and 0xBFFE sets mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_rdata | output | 8 | CPU read data |
| rom_rdata | input | 8 | Program-ROM read data |
| wram_rdata | input | 8 | Work-RAM read data |
| cfg_prg_bank_cnt | input | 7 | Number of 8 KB program pages (static) |
| cfg_chr_rom_present | input | 1 | Pattern ROM fitted (static) |
| cfg_four_screen | input | 1 | Four-screen strap (static) |
| prg_rom_addr | output | 19 | Physical program-ROM address |
| wram_sel | output | 1 | Work-RAM window hit |
| wram_we | output | 1 | Work-RAM write enable |
| wram_addr | output | 13 | Work-RAM address |
| ppu_addr | input | 14 | Graphics-side address |
| ppu_we | input | 1 | Graphics-side write strobe |
| chr_addr | output | 18 | Physical pattern address |
| chr_ram_we | output | 1 | Pattern-RAM write enable |
| mirror_mode | output | 2 | 0 vertical, 1 horizontal, 2 four-screen |

## Verification
The assertions check the invariants on every cycle:
- the stored-value masks of registers 0, 1, 6 and 7;
- the last-page window, which is fixed in both modes;
- the pattern offset bits passing through unchanged;
- the four-screen override, and the zero read data outside the mapped ranges;
- the mode bits being loaded from a select write.

Only the bench's scenarios can show the mapping of each window under both modes with real register contents. The same holds for the indirect targeting through the select register, the decoding of aliased addresses, and the writes that must leave state untouched. The bench observes those writes through the translated addresses afterwards.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;
    localparam int PRG_PAGE_W   = 6;
    localparam int BANK_W       = 8;
    localparam int NUM_BANKS    = 8;
    localparam int TGT_W        = $clog2(NUM_BANKS);
    localparam int PRG_OFF_W    = 13;
    localparam int CHR_OFF_W    = 10;
    localparam int PRG_ADDR_W   = PRG_PAGE_W + PRG_OFF_W;
    localparam int CHR_ADDR_W   = BANK_W + CHR_OFF_W;
    localparam int PRG_CNT_W    = PRG_PAGE_W + 1;

    typedef enum logic [1:0] {
        MIR_VERT = 2'd0,
        MIR_HORZ = 2'd1,
        MIR_FOUR = 2'd2
    } mirror_e;

    typedef struct packed {
        logic [TGT_W-1:0]                      target;
        logic                                  prg_swap;
        logic                                  chr_swap;
        logic                                  mirror_h;
        logic [NUM_BANKS-1:0][BANK_W-1:0]      bank;
    } map_state_t;

    // Per-register keep mask applied on a data write
    function automatic logic [BANK_W-1:0] bank_keep(input logic [TGT_W-1:0] idx);
        logic [BANK_W-1:0] m;
        case (idx)
            3'd0, 3'd1: m = {{(BANK_W-1){1'b1}}, 1'b0};
            3'd6, 3'd7: m = BANK_W'((1 << PRG_PAGE_W) - 1);
            default:    m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import cart_mapper_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [1:0]                       wr_region,
    input  logic                             wr_odd,
    input  logic [BANK_W-1:0]                wr_data,
    output logic                             prg_swap,
    output logic                             chr_swap,
    output logic                             mirror_h,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] bank
);
    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_region)
                2'd0: begin
                    if (!wr_odd) begin
                        st_d.target   = wr_data[TGT_W-1:0];
                        st_d.prg_swap = wr_data[6];
                        st_d.chr_swap = wr_data[7];
                    end else begin
                        st_d.bank[st_q.target] = wr_data & bank_keep(st_q.target);
                    end
                end
                2'd1: begin
                    if (!wr_odd) st_d.mirror_h = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prg_swap = st_q.prg_swap;
    assign chr_swap = st_q.chr_swap;
    assign mirror_h = st_q.mirror_h;
    assign bank     = st_q.bank;
endmodule

// File: rtl/prg_xlate.sv
module prg_xlate
    import cart_mapper_pkg::*;
(
    input  logic [15:0]             cpu_addr,
    input  logic                    prg_swap,
    input  logic [BANK_W-1:0]       reg_a,
    input  logic [BANK_W-1:0]       reg_b,
    input  logic [PRG_CNT_W-1:0]    page_cnt,
    output logic [PRG_ADDR_W-1:0]   prg_rom_addr
);
    logic [PRG_CNT_W-1:0]  last_full, penult_full;
    logic [PRG_PAGE_W-1:0] page;
    logic [BANK_W-1:0]     pick;

    assign last_full   = page_cnt - PRG_CNT_W'(1);
    assign penult_full = page_cnt - PRG_CNT_W'(2);

    always_comb begin
        pick = '0;
        case ({prg_swap, cpu_addr[14:13]})
            3'b000, 3'b110: pick = reg_a;
            3'b001, 3'b101: pick = reg_b;
            3'b010, 3'b100: pick = BANK_W'(penult_full);
            default:        pick = BANK_W'(last_full);
        endcase
        page = pick[PRG_PAGE_W-1:0];
    end

    assign prg_rom_addr = {page, cpu_addr[PRG_OFF_W-1:0]};

    logic unused_ok;
    assign unused_ok = ^{cpu_addr[15], pick[BANK_W-1:PRG_PAGE_W]};
endmodule

// File: rtl/chr_xlate.sv
module chr_xlate
    import cart_mapper_pkg::*;
(
    input  logic [12:0]                      pat_addr,
    input  logic                             chr_swap,
    input  logic                             rom_present,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank,
    output logic [CHR_ADDR_W-1:0]            chr_addr
);
    logic              half;
    logic [BANK_W-1:0] page;
    logic [1:0]        fine_idx;

    always_comb begin
        half     = pat_addr[12] ^ chr_swap;
        fine_idx = pat_addr[11:10];
        if (!half) begin
            page = bank[{2'b00, pat_addr[11]}] | BANK_W'(pat_addr[10]);
        end else begin
            page = bank[3'd2 + {1'b0, fine_idx}];
        end
        if (rom_present) chr_addr = {page, pat_addr[CHR_OFF_W-1:0]};
        else             chr_addr = CHR_ADDR_W'(pat_addr);
    end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_wdata,
    input  logic                   cpu_we,
    output logic [7:0]             cpu_rdata,
    input  logic [7:0]             rom_rdata,
    input  logic [7:0]             wram_rdata,
    input  logic [PRG_CNT_W-1:0]   cfg_prg_bank_cnt,
    input  logic                   cfg_chr_rom_present,
    input  logic                   cfg_four_screen,
    output logic [PRG_ADDR_W-1:0]  prg_rom_addr,
    output logic                   wram_sel,
    output logic                   wram_we,
    output logic [12:0]            wram_addr,
    input  logic [13:0]            ppu_addr,
    input  logic                   ppu_we,
    output logic [CHR_ADDR_W-1:0]  chr_addr,
    output logic                   chr_ram_we,
    output logic [1:0]             mirror_mode
);
    logic                             prg_swap, chr_swap, mirror_h;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank;
    logic [1:0]                       r01_lsb;
    logic [3:0]                       r67_top;

    mapper_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_we & cpu_addr[15]),
        .wr_region (cpu_addr[14:13]),
        .wr_odd    (cpu_addr[0]),
        .wr_data   (cpu_wdata),
        .prg_swap  (prg_swap),
        .chr_swap  (chr_swap),
        .mirror_h  (mirror_h),
        .bank      (bank)
    );

    prg_xlate u_prg (
        .cpu_addr     (cpu_addr),
        .prg_swap     (prg_swap),
        .reg_a        (bank[6]),
        .reg_b        (bank[7]),
        .page_cnt     (cfg_prg_bank_cnt),
        .prg_rom_addr (prg_rom_addr)
    );

    chr_xlate u_chr (
        .pat_addr    (ppu_addr[12:0]),
        .chr_swap    (chr_swap),
        .rom_present (cfg_chr_rom_present),
        .bank        (bank),
        .chr_addr    (chr_addr)
    );

    logic in_wram;
    assign in_wram   = (cpu_addr[15:13] == 3'b011);
    assign wram_sel  = in_wram;
    assign wram_we   = in_wram & cpu_we;
    assign wram_addr = cpu_addr[12:0];

    always_comb begin
        if (cpu_addr[15]) cpu_rdata = rom_rdata;
        else if (in_wram) cpu_rdata = wram_rdata;
        else              cpu_rdata = 8'h00;
    end

    assign chr_ram_we = ppu_we & ~ppu_addr[13] & ~cfg_chr_rom_present;

    always_comb begin
        if (cfg_four_screen) mirror_mode = MIR_FOUR;
        else if (mirror_h)   mirror_mode = MIR_HORZ;
        else                 mirror_mode = MIR_VERT;
    end

    assign r01_lsb = {bank[1][0], bank[0][0]};
    assign r67_top = {bank[7][7:6], bank[6][7:6]};
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk
    import cart_mapper_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:0]           cpu_addr,
    input logic [7:0]            cpu_wdata,
    input logic                  cpu_we,
    input logic [7:0]            cpu_rdata,
    input logic [PRG_CNT_W-1:0]  cfg_prg_bank_cnt,
    input logic                  cfg_chr_rom_present,
    input logic                  cfg_four_screen,
    input logic [PRG_ADDR_W-1:0] prg_rom_addr,
    input logic [13:0]           ppu_addr,
    input logic [CHR_ADDR_W-1:0] chr_addr,
    input logic [1:0]            mirror_mode,
    input logic                  prg_swap,
    input logic                  chr_swap,
    input logic [1:0]            r01_lsb,
    input logic [3:0]            r67_top
);
    logic [PRG_CNT_W-1:0] last_pg;
    assign last_pg = cfg_prg_bank_cnt - PRG_CNT_W'(1);

    assert_r01_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r01_lsb == 2'b00);
    assert_r67_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r67_top == 4'b0000);
    assert_last_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_ADDR_W-1:PRG_OFF_W] == last_pg[PRG_PAGE_W-1:0]));
    assert_prg_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_addr[PRG_OFF_W-1:0] == cpu_addr[PRG_OFF_W-1:0]);
    assert_chr_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chr_rom_present |-> (chr_addr[CHR_OFF_W-1:0] == ppu_addr[CHR_OFF_W-1:0]));
    assert_four_screen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_four_screen |-> (mirror_mode == MIR_FOUR));
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] < 3'b011) |-> (cpu_rdata == 8'h00));
    assert_select_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15:13] == 3'b100 && !cpu_addr[0])
        |=> (prg_swap == $past(cpu_wdata[6]) && chr_swap == $past(cpu_wdata[7])));
endmodule

bind cart_mapper cart_mapper_chk u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .cpu_addr            (cpu_addr),
    .cpu_wdata           (cpu_wdata),
    .cpu_we              (cpu_we),
    .cpu_rdata           (cpu_rdata),
    .cfg_prg_bank_cnt    (cfg_prg_bank_cnt),
    .cfg_chr_rom_present (cfg_chr_rom_present),
    .cfg_four_screen     (cfg_four_screen),
    .prg_rom_addr        (prg_rom_addr),
    .ppu_addr            (ppu_addr),
    .chr_addr            (chr_addr),
    .mirror_mode         (mirror_mode),
    .prg_swap            (prg_swap),
    .chr_swap            (chr_swap),
    .r01_lsb             (r01_lsb),
    .r67_top             (r67_top)
);

// File: tb/cart_mapper_test.sv
module cart_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  rom_rdata = 8'h5A;
    logic [7:0]  wram_rdata = 8'hC3;
    logic [6:0]  cfg_prg_bank_cnt = 7'd16;
    logic        cfg_chr_rom_present = 1'b1;
    logic        cfg_four_screen = 1'b0;
    logic [18:0] prg_rom_addr;
    logic        wram_sel, wram_we;
    logic [12:0] wram_addr;
    logic [13:0] ppu_addr = '0;
    logic        ppu_we = 1'b0;
    logic [17:0] chr_addr;
    logic        chr_ram_we;
    logic [1:0]  mirror_mode;

    cart_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .rom_rdata(rom_rdata),
        .wram_rdata(wram_rdata), .cfg_prg_bank_cnt(cfg_prg_bank_cnt),
        .cfg_chr_rom_present(cfg_chr_rom_present), .cfg_four_screen(cfg_four_screen),
        .prg_rom_addr(prg_rom_addr), .wram_sel(wram_sel), .wram_we(wram_we),
        .wram_addr(wram_addr), .ppu_addr(ppu_addr), .ppu_we(ppu_we),
        .chr_addr(chr_addr), .chr_ram_we(chr_ram_we), .mirror_mode(mirror_mode)
    );

    always #10 clk = ~clk;

    typedef enum int {K_PRG, K_CHR, K_MIR, K_RD, K_WRAM, K_CRWE} kind_e;
    typedef struct {
        kind_e kind;
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // Monitor: samples mid-cycle after the driver has set up the stimulus
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                int    act;
                it = sb.pop_front();
                case (it.kind)
                    K_PRG:  act = int'(prg_rom_addr);
                    K_CHR:  act = int'(chr_addr);
                    K_MIR:  act = int'(mirror_mode);
                    K_RD:   act = int'(cpu_rdata);
                    K_WRAM: act = int'({wram_sel, wram_we, wram_addr});
                    default: act = int'(chr_ram_we);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic cpu_check(input kind_e k, input logic [15:0] a, input logic we,
                             input int exp, input string tag);
        item_t it;
        cpu_addr  = a;
        cpu_we    = we;
        cpu_wdata = 8'h00;
        it.kind = k; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic ppu_check(input kind_e k, input logic [13:0] a, input logic we,
                             input int exp, input string tag);
        item_t it;
        ppu_addr = a;
        ppu_we   = we;
        it.kind = k; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        ppu_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cpu_check(K_PRG, 16'h8010, 0, 'h00010, "R1 reg6 page 0");
        cpu_check(K_PRG, 16'hC000, 0, 14*8192, "R1 R4 second-last page");
        cpu_check(K_PRG, 16'hE000, 0, 15*8192, "R1 R4 last page");
        cpu_check(K_MIR, 16'h0000, 0, 0, "R1 mirror vertical");
        ppu_check(K_CHR, 14'h1000, 0, 0, "R1 reg2 zero");

        // R3: masking on registers 6 and 7
        cpu_write(16'h8000, 8'h06);
        cpu_write(16'h8001, 8'hC5);
        cpu_check(K_PRG, 16'h8123, 0, 5*8192 + 'h123, "R3 reg6 masked");
        cpu_write(16'h8000, 8'h07);
        cpu_write(16'h8001, 8'hFF);
        cpu_check(K_PRG, 16'hA456, 0, 63*8192 + 'h456, "R3 R4 reg7 masked");

        // R2/R4: program mode 1, bit 5 set too
        cpu_write(16'h8000, 8'h66);
        cpu_check(K_PRG, 16'h8000, 0, 14*8192, "R4 mode1 first window");
        cpu_check(K_PRG, 16'hC001, 0, 5*8192 + 1, "R4 mode1 third window");
        cpu_check(K_PRG, 16'hE002, 0, 15*8192 + 2, "R4 mode1 last window");
        cpu_check(K_PRG, 16'hA000, 0, 63*8192, "R2 bit5 ignored reg7 intact");

        // R3/R5: pattern registers
        cpu_write(16'h8000, 8'h40); cpu_write(16'h8001, 8'h13);
        cpu_write(16'h8000, 8'h41); cpu_write(16'h8001, 8'h20);
        cpu_write(16'h8000, 8'h42); cpu_write(16'h8001, 8'h07);
        cpu_write(16'h8000, 8'h45); cpu_write(16'h8001, 8'hAB);
        ppu_check(K_CHR, 14'h0400, 0, 'h13*1024, "R3 R5 reg0 bit0 cleared");
        ppu_check(K_CHR, 14'h0C05, 0, 'h21*1024 + 5, "R5 reg1 upper 1K");
        ppu_check(K_CHR, 14'h1003, 0, 7*1024 + 3, "R5 reg2 window");
        ppu_check(K_CHR, 14'h1FFF, 0, 'hAB*1024 + 'h3FF, "R5 reg5 full byte");

        // R2/R5: pattern mode 1, program back to mode 0
        cpu_write(16'h8000, 8'h80);
        ppu_check(K_CHR, 14'h0003, 0, 7*1024 + 3, "R5 mode1 low half reg2");
        ppu_check(K_CHR, 14'h0C00, 0, 'hAB*1024, "R5 mode1 low half reg5");
        ppu_check(K_CHR, 14'h1400, 0, 'h13*1024, "R5 mode1 high half reg0");
        ppu_check(K_CHR, 14'h1C05, 0, 'h21*1024 + 5, "R5 mode1 high half reg1");
        cpu_check(K_PRG, 16'h8000, 0, 5*8192, "R2 program mode cleared");

        // R6/R10/R11: mirroring
        cpu_write(16'hA000, 8'h01);
        cpu_check(K_MIR, 16'h0000, 0, 1, "R6 horizontal");
        cpu_write(16'hA001, 8'h00);
        cpu_check(K_MIR, 16'h0000, 0, 1, "R10 odd A000 ignored");
        cpu_write(16'hBFFE, 8'h00);
        cpu_check(K_MIR, 16'h0000, 0, 0, "R11 BFFE alias sets mirroring");
        cpu_write(16'hA000, 8'h01);
        cfg_four_screen = 1'b1;
        cpu_check(K_MIR, 16'h0000, 0, 2, "R6 four-screen override");
        cfg_four_screen = 1'b0;
        cpu_check(K_MIR, 16'h0000, 0, 1, "R6 override released");

        // R10: writes outside the decoded ranges
        cpu_write(16'hC000, 8'hFF);
        cpu_write(16'hE001, 8'h01);
        cpu_write(16'hD001, 8'h3C);
        cpu_write(16'h4000, 8'h00);
        cpu_write(16'h6000, 8'h55);
        cpu_check(K_PRG, 16'h8000, 0, 5*8192, "R10 reg6 unchanged");
        cpu_check(K_MIR, 16'h0000, 0, 1, "R10 mirroring unchanged");
        ppu_check(K_CHR, 14'h0003, 0, 7*1024 + 3, "R10 pattern mode unchanged");

        // R11: aliased select/data
        cpu_write(16'h9FFE, 8'h46);
        cpu_write(16'h9FFF, 8'h09);
        cpu_check(K_PRG, 16'hC000, 0, 9*8192, "R11 9FFE/9FFF aliases");

        // R7: work RAM window
        cpu_check(K_WRAM, 16'h6ABC, 0, (1 << 14) | 'h0ABC, "R7 wram read window");
        cpu_check(K_WRAM, 16'h7001, 1, (1 << 14) | (1 << 13) | 'h1001, "R7 wram write");
        cpu_check(K_WRAM, 16'h5FFF, 1, 'h1FFF, "R7 outside window");

        // R9: read data mux
        cpu_check(K_RD, 16'h9000, 0, 'h5A, "R9 rom data");
        cpu_check(K_RD, 16'h6000, 0, 'hC3, "R9 wram data");
        cpu_check(K_RD, 16'h4020, 0, 0, "R9 unmapped zero");

        // R8: pattern RAM
        ppu_check(K_CRWE, 14'h1234, 1, 0, "R8 rom present blocks write");
        cfg_chr_rom_present = 1'b0;
        ppu_check(K_CRWE, 14'h1234, 1, 1, "R8 pattern ram write");
        ppu_check(K_CHR, 14'h1234, 0, 'h1234, "R8 unbanked address");
        ppu_check(K_CRWE, 14'h2000, 1, 0, "R8 nametable space no write");
        cfg_chr_rom_present = 1'b1;

        // R1: reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_check(K_PRG, 16'h8000, 0, 0, "R1 reset clears reg6 and mode");
        cpu_check(K_MIR, 16'h0000, 0, 0, "R1 reset clears mirroring");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule